// File: doc/BRIEF.md
# Timed Fuse and Lock Access Controller

This block sits beside the program-memory read path of a small processor. It holds a self-programming control register that opens a short, cycle-counted window. During that window, load and store instructions reach the configuration fuse bytes, the lock byte and a factory signature row instead of ordinary program memory. Outside the window every load returns the program-memory byte it was handed.

Software writes a command pattern to the control register. The window then opens. A load or store is special only if it arrives within a fixed number of cycles after that write. The armed bits clear themselves: on completion, when the window runs out, or for a signature command after a fixed hold time. The register refuses new commands while anything is armed. Lock bits are held in a register that models nonvolatile storage. They can only move from unprogrammed (1) to programmed (0). The fuse bytes, the initial lock byte and the signature row are parameters.

Top module: `fuse_lock_ctrl`

## Requirements
- R1: Control bit 0 is the enable, bit 3 is the lock/fuse select and bit 5 is the signature select. A write whose bits 6:0 equal 0x09 arms lock/fuse mode. A write whose bits 6:0 equal 0x21 arms signature mode. Bit 7 is ignored. Any other pattern leaves the register at zero. `ctl_rdata` shows the armed bits, and every other bit reads 0.
- R2: In lock/fuse mode, a load sampled 1 to 3 cycles after the command write returns a byte chosen by the pointer: 0x0000 gives fuse low, 0x0001 gives the lock byte, 0x0003 gives fuse high, and any other pointer gives 0xFF.
- R3: `ld_data` is registered. It updates on the clock edge that samples `ld_req`. A load that is not special (idle, past its window, or an unknown command) returns `pm_rdata` unchanged.
- R4: In signature mode, a load sampled 1 to 3 cycles after the write returns byte N of the signature table for pointer N. A pointer at or beyond the table depth returns 0xFF.
- R5: Signature mode stays armed through cycle 5 and clears on the 6th edge after the write. While either mode is armed, control writes are ignored.
- R6: Lock/fuse mode clears on the edge that samples a qualifying load or store. If no such load or store comes, it clears on the 4th edge after the write.
- R7: In lock/fuse mode, a store sampled 1 to 4 cycles after the write sets lock bits 5:0 to the AND of the old bits and operand bits 5:0. The pointer is ignored. Lock bits 7:6 always read 1, and no bit ever returns from 0 to 1.
- R8: A store outside the window, or with nothing armed, leaves the lock byte unchanged.
- R9: After reset, `ctl_rdata` and `ld_data` are 0 and the lock byte equals the lock parameter with bits 7:6 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| ld_req | input | 1 | Load instruction strobe |
| ld_addr | input | 16 | Load pointer |
| pm_rdata | input | 8 | Program-memory byte for the current load |
| ld_data | output | 8 | Registered load result |
| st_req | input | 1 | Store instruction strobe |
| st_data | input | 8 | Store operand |

## Verification
A wrong internal state mostly shows up one cycle after the load that would expose it. A mode bit stuck or cleared too early turns a special read into the program-memory byte, or the reverse, in `ld_data` on the next cycle. It also shows at once in `ctl_rdata`. A window counter that is off by one appears only at the boundary delays of 3, 4, 5 and 6 cycles. For that reason those delays are exercised on purpose. A corrupted lock register stays hidden until the next lock read, so every store in the bench is followed by such a read.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CFG  = 2'd1,
    MODE_SIG  = 2'd2
  } flc_mode_e;

  localparam int BIT_EN  = 0;
  localparam int BIT_CFG = 3;
  localparam int BIT_SIG = 5;

  localparam logic [6:0] PAT_CFG = 7'h09;
  localparam logic [6:0] PAT_SIG = 7'h21;

  localparam logic [15:0] ADR_FUSE_LO = 16'h0000;
  localparam logic [15:0] ADR_LOCK    = 16'h0001;
  localparam logic [15:0] ADR_FUSE_HI = 16'h0003;
endpackage

// File: rtl/flc_cmd_reg.sv
module flc_cmd_reg
  import flc_pkg::*;
#(
  parameter int LD_WIN   = 3,
  parameter int ST_WIN   = 4,
  parameter int SIG_HOLD = 6,
  localparam int AW = $clog2(SIG_HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          ld_req,
  input  logic          st_req,
  output flc_mode_e     mode,
  output logic [AW-1:0] age,
  output logic          ld_hit,
  output logic          st_hit,
  output logic [7:0]    ctl_rdata
);
  localparam logic [AW-1:0] LDW = AW'(LD_WIN);
  localparam logic [AW-1:0] STW = AW'(ST_WIN);
  localparam logic [AW-1:0] SGH = AW'(SIG_HOLD);

  assign ld_hit = ld_req && (mode != MODE_IDLE) && (age <= LDW);
  assign st_hit = st_req && (mode == MODE_CFG) && (age <= STW);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_IDLE;
      age  <= '0;
    end else begin
      case (mode)
        MODE_IDLE: begin
          if (ctl_we && ctl_wdata[6:0] == PAT_CFG) begin
            mode <= MODE_CFG;
            age  <= AW'(1);
          end else if (ctl_we && ctl_wdata[6:0] == PAT_SIG) begin
            mode <= MODE_SIG;
            age  <= AW'(1);
          end
        end
        MODE_CFG: begin
          age <= age + AW'(1);
          if (ld_hit || st_hit || age >= STW) begin
            mode <= MODE_IDLE;
            age  <= '0;
          end
        end
        default: begin
          age <= age + AW'(1);
          if (age >= SGH) begin
            mode <= MODE_IDLE;
            age  <= '0;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl_rdata = 8'h00;
    ctl_rdata[BIT_EN]  = (mode != MODE_IDLE);
    ctl_rdata[BIT_CFG] = (mode == MODE_CFG);
    ctl_rdata[BIT_SIG] = (mode == MODE_SIG);
  end
endmodule

// File: rtl/flc_nv_store.sv
module flc_nv_store
  import flc_pkg::*;
#(
  parameter logic [7:0] LOCK_INIT    = 8'hFF,
  parameter logic [7:0] FUSE_LO_INIT = 8'hDE,
  parameter logic [7:0] FUSE_HI_INIT = 8'hE9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        st_hit,
  input  logic [7:0]  st_data,
  input  logic [15:0] addr,
  output logic [7:0]  rd_byte,
  output logic [7:0]  lock_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_byte <= LOCK_INIT | 8'hC0;
    end else if (st_hit) begin
      lock_byte <= lock_byte & {2'b11, st_data[5:0]};
    end
  end

  always_comb begin
    case (addr)
      ADR_FUSE_LO: rd_byte = FUSE_LO_INIT;
      ADR_LOCK:    rd_byte = lock_byte;
      ADR_FUSE_HI: rd_byte = FUSE_HI_INIT;
      default:     rd_byte = 8'hFF;
    endcase
  end
endmodule

// File: rtl/flc_sig_rom.sv
module flc_sig_rom #(
  parameter int                     SIG_DEPTH = 3,
  parameter logic [SIG_DEPTH*8-1:0] SIG_ROM   = 24'h3CA751,
  localparam int IW = (SIG_DEPTH > 1) ? $clog2(SIG_DEPTH) : 1
) (
  input  logic [15:0] addr,
  output logic [7:0]  rd_byte
);
  logic [7:0] tbl [2**IW];

  for (genvar g = 0; g < 2**IW; g++) begin : g_row
    if (g < SIG_DEPTH) begin : g_used
      assign tbl[g] = SIG_ROM[g*8 +: 8];
    end else begin : g_pad
      assign tbl[g] = 8'hFF;
    end
  end

  assign rd_byte = (addr < 16'(SIG_DEPTH)) ? tbl[addr[IW-1:0]] : 8'hFF;
endmodule

// File: rtl/fuse_lock_ctrl.sv
module fuse_lock_ctrl
  import flc_pkg::*;
#(
  parameter int                     LD_WIN       = 3,
  parameter int                     ST_WIN       = 4,
  parameter int                     SIG_HOLD     = 6,
  parameter logic [7:0]             LOCK_INIT    = 8'hFF,
  parameter logic [7:0]             FUSE_LO_INIT = 8'hDE,
  parameter logic [7:0]             FUSE_HI_INIT = 8'hE9,
  parameter int                     SIG_DEPTH    = 3,
  parameter logic [SIG_DEPTH*8-1:0] SIG_ROM      = 24'h3CA751,
  localparam int AW = $clog2(SIG_HOLD + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata,
  input  logic        ld_req,
  input  logic [15:0] ld_addr,
  input  logic [7:0]  pm_rdata,
  output logic [7:0]  ld_data,
  input  logic        st_req,
  input  logic [7:0]  st_data
);
  flc_mode_e     mode;
  logic [AW-1:0] arm_age;
  logic          ld_hit, st_hit;
  logic [7:0]    cfg_byte, sig_byte, lock_byte;

  flc_cmd_reg #(.LD_WIN(LD_WIN), .ST_WIN(ST_WIN), .SIG_HOLD(SIG_HOLD)) u_cmd (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ld_req(ld_req), .st_req(st_req), .mode(mode), .age(arm_age),
    .ld_hit(ld_hit), .st_hit(st_hit), .ctl_rdata(ctl_rdata)
  );

  flc_nv_store #(.LOCK_INIT(LOCK_INIT), .FUSE_LO_INIT(FUSE_LO_INIT),
                 .FUSE_HI_INIT(FUSE_HI_INIT)) u_nv (
    .clk(clk), .rst(rst), .st_hit(st_hit), .st_data(st_data),
    .addr(ld_addr), .rd_byte(cfg_byte), .lock_byte(lock_byte)
  );

  flc_sig_rom #(.SIG_DEPTH(SIG_DEPTH), .SIG_ROM(SIG_ROM)) u_sig (
    .addr(ld_addr), .rd_byte(sig_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_data <= 8'h00;
    end else if (ld_req) begin
      if (!ld_hit)               ld_data <= pm_rdata;
      else if (mode == MODE_SIG) ld_data <= sig_byte;
      else                       ld_data <= cfg_byte;
    end
  end
endmodule

// File: rtl/flc_chk.sv
module flc_chk
  import flc_pkg::*;
#(
  parameter int ST_WIN   = 4,
  parameter int SIG_HOLD = 6,
  parameter int AW       = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    ctl_rdata,
  input logic          ld_req,
  input logic [7:0]    pm_rdata,
  input logic [7:0]    ld_data,
  input flc_mode_e     mode,
  input logic [AW-1:0] arm_age,
  input logic [7:0]    lock_byte
);
  localparam logic [AW-1:0] STW = AW'(ST_WIN);
  localparam logic [AW-1:0] SGH = AW'(SIG_HOLD);

  // R1
  ctl_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata == 8'h00 || ctl_rdata == 8'h09 || ctl_rdata == 8'h21));

  // R3
  pm_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_req && mode == MODE_IDLE) |=> (ld_data == $past(pm_rdata)));

  // R5
  sig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SIG && arm_age < SGH) |=> (mode == MODE_SIG));

  // R5
  sig_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SIG && arm_age >= SGH) |=> (mode == MODE_IDLE));

  // R6
  cfg_expire_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CFG && arm_age >= STW) |=> (mode == MODE_IDLE));

  // R7
  lock_mono_chk: assert property (@(posedge clk) disable iff (rst)
    ((lock_byte & ~$past(lock_byte)) == 8'h00));

  // R7
  lock_top_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_byte[7:6] == 2'b11));
endmodule

bind fuse_lock_ctrl flc_chk #(.ST_WIN(ST_WIN), .SIG_HOLD(SIG_HOLD), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ctl_rdata(ctl_rdata), .ld_req(ld_req),
  .pm_rdata(pm_rdata), .ld_data(ld_data), .mode(mode),
  .arm_age(arm_age), .lock_byte(lock_byte)
);

// File: tb/sim_fuse_lock_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_lock_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic [7:0]  ctl_rdata;
  logic        ld_req = 1'b0;
  logic [15:0] ld_addr = 16'h0000;
  logic [7:0]  pm_rdata;
  logic [7:0]  ld_data;
  logic        st_req = 1'b0;
  logic [7:0]  st_data = 8'h00;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign pm_rdata = ld_addr[7:0] ^ 8'h5A;

  fuse_lock_ctrl u0 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ld_req(ld_req), .ld_addr(ld_addr),
    .pm_rdata(pm_rdata), .ld_data(ld_data), .st_req(st_req), .st_data(st_data)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // req4 | cmd8 | delay4 | kind4 (0 load, 1 store) | addr16 | data8 | exp8
  localparam int NV = 22;
  localparam logic [51:0] VEC [NV] = '{
    {4'd2, 8'h09, 4'd1, 4'd0, 16'h0000, 8'h00, 8'hDE}, // R2 fuse low
    {4'd2, 8'h09, 4'd3, 4'd0, 16'h0003, 8'h00, 8'hE9}, // R2 fuse high, last cycle
    {4'd2, 8'h09, 4'd2, 4'd0, 16'h0001, 8'h00, 8'hFF}, // R2 lock at reset value
    {4'd3, 8'h09, 4'd4, 4'd0, 16'h0001, 8'h00, 8'h5B}, // R3 past load window
    {4'd4, 8'h21, 4'd1, 4'd0, 16'h0000, 8'h00, 8'h51}, // R4 signature byte 0
    {4'd4, 8'h21, 4'd3, 4'd0, 16'h0002, 8'h00, 8'h3C}, // R4 signature byte 2
    {4'd3, 8'h21, 4'd4, 4'd0, 16'h0001, 8'h00, 8'h5B}, // R3 signature past window
    {4'd4, 8'h21, 4'd2, 4'd0, 16'h0005, 8'h00, 8'hFF}, // R4 beyond table
    {4'd2, 8'h09, 4'd2, 4'd0, 16'h0002, 8'h00, 8'hFF}, // R2 undefined pointer
    {4'd7, 8'h09, 4'd4, 4'd1, 16'h1234, 8'hF6, 8'h00}, // R7 store at window edge
    {4'd7, 8'h09, 4'd1, 4'd0, 16'h0001, 8'h00, 8'hF6}, // R7 result
    {4'd8, 8'h09, 4'd5, 4'd1, 16'h0001, 8'h00, 8'h00}, // R8 late store
    {4'd8, 8'h09, 4'd1, 4'd0, 16'h0001, 8'h00, 8'hF6}, // R8 unchanged
    {4'd8, 8'h00, 4'd1, 4'd1, 16'h0001, 8'h00, 8'h00}, // R8 store unarmed
    {4'd8, 8'h09, 4'd1, 4'd0, 16'h0001, 8'h00, 8'hF6}, // R8 unchanged
    {4'd7, 8'h09, 4'd2, 4'd1, 16'h0000, 8'hFF, 8'h00}, // R7 try to unprogram
    {4'd7, 8'h09, 4'd1, 4'd0, 16'h0001, 8'h00, 8'hF6}, // R7 still programmed
    {4'd3, 8'h00, 4'd1, 4'd0, 16'h0001, 8'h00, 8'h5B}, // R3 idle passthrough
    {4'd1, 8'h89, 4'd1, 4'd0, 16'h0000, 8'h00, 8'hDE}, // R1 bit 7 ignored
    {4'd1, 8'h03, 4'd1, 4'd0, 16'h0000, 8'h00, 8'h5A}, // R1 bad pattern not armed
    {4'd7, 8'h09, 4'd3, 4'd1, 16'hBEEF, 8'h30, 8'h00}, // R7 bits 7:6 fixed
    {4'd7, 8'h09, 4'd1, 4'd0, 16'h0001, 8'h00, 8'hF0}  // R7 result
  };

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 ctl_rdata", ctl_rdata, 8'h00);
    check("R9 ld_data", ld_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[51:48], i);
      if (v[47:40] != 8'h00) begin
        ctl_write(v[47:40]);
        repeat (int'(v[39:36]) - 1) @(negedge clk);
      end else begin
        @(negedge clk);
      end
      ld_addr = v[31:16];
      st_data = v[15:8];
      if (v[35:32] == 4'd0) ld_req = 1'b1; else st_req = 1'b1;
      @(negedge clk);
      ld_req = 1'b0; st_req = 1'b0;
      if (v[35:32] == 4'd0) check(tag, ld_data, v[7:0]);
      repeat (8) @(negedge clk);
    end

    // R1 readback of lock/fuse mode, R5 write ignored while armed
    ctl_write(8'h09);
    check("R1 cfg readback", ctl_rdata, 8'h09);
    ctl_write(8'h21);
    check("R5 write while armed", ctl_rdata, 8'h09);
    // R6 expiry on 4th edge: write edge T, now after T+2
    @(negedge clk);
    check("R6 armed at cycle 3", ctl_rdata, 8'h09);
    @(negedge clk);
    check("R6 cleared at cycle 4", ctl_rdata, 8'h00);

    // R5 signature hold through 5, cleared at 6
    ctl_write(8'h21);
    check("R1 sig readback", ctl_rdata, 8'h21);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h09;
    @(negedge clk); ctl_we = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 held at cycle 5", ctl_rdata, 8'h21);
    @(negedge clk);
    check("R5 cleared at cycle 6", ctl_rdata, 8'h00);

    // R6 clear on completed load
    ctl_write(8'h09);
    ld_addr = 16'h0003; ld_req = 1'b1;
    @(negedge clk); ld_req = 1'b0;
    check("R6 load data", ld_data, 8'hE9);
    check("R6 cleared after load", ctl_rdata, 8'h00);

    // R3 signature mode still armed but past load window
    ctl_write(8'h21);
    repeat (3) @(negedge clk);
    ld_addr = 16'h0000; ld_req = 1'b1;
    @(negedge clk); ld_req = 1'b0;
    check("R3 sig late load", ld_data, 8'h5A);
    check("R5 sig still armed", ctl_rdata, 8'h21);

    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule